// File: doc/BRIEF.md
# Burst Envelope Ramp Generator

This block softens the power edges of a transmitted burst. It sits after a baseband modulator and multiplies each signed I and Q sample by a gain. The gain follows a raised-cosine curve that climbs from silence to full scale over two symbol periods when a burst begins. It stays at full scale while the burst runs. It falls back to silence over two symbol periods after the burst ends, and it then holds two more symbol periods of enforced silence. Samples arrive on a one-cycle strobe, and a parameter sets the number of samples in each symbol. Each scaled output pair is registered on the strobe edge that presents its input, and holds until the next strobe.

The gain is a 10-bit unsigned fraction where 512 means unity. The curve values are computed when the design is elaborated and stored in a table that the rise and the fall share. The fall reads that table with a mirrored index. If the burst flag drops before the rise has finished, the fall starts from the level already reached, so the gain never jumps. A done flag goes high when the quiet tail is over. A burst flag that is high at that point, or that rises later, starts the next ramp-up.

Top module: `burst_ramp`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `i_out` and `q_out` become 0 and `done_o` becomes 0 at that edge, and the block returns to idle.
- R2: While idle, or after the tail has completed, a strobe taken with `burst_i` low produces output samples of 0.
- R3: The strobe that sees `burst_i` high in the idle or done state is ramp-up sample k=0. For ramp-up samples k = 0 … 2·SPS−1 the gain is round(512·(0.5 − 0.5·cos(π·k/(2·SPS)))), which is 0 at k=0.
- R4: After the ramp-up, and for as long as `burst_i` stays high, the gain is exactly 512, so each output equals its input.
- R5: The first strobe that sees `burst_i` low after full scale is ramp-down sample k=0. For k = 0 … 2·SPS−1 the gain is round(512·(0.5 + 0.5·cos(π·k/(2·SPS)))).
- R6: The 2·SPS strobes after the ramp-down output 0 whatever their input, and `done_o` stays low during them.
- R7: `done_o` rises on the edge of the last tail strobe. It stays high until a strobe starts a new ramp-up, and it falls on that strobe's edge.
- R8: Each output is floor((x·g + 256)/512), where x is the input and g is the gain. This rounds half up, and the result is clamped to the signed sample range.
- R9: Outputs and `done_o` change only on clock edges where `strobe_i` is high or `rst` is high.
- R10: If `burst_i` falls at ramp-up sample c, that strobe keeps gain up(c). The following strobes take up(c−1), …, up(1), and then the silent tail follows.
- R11: Changes of `burst_i` during the ramp-down or the tail have no effect. The fall and the tail run to completion, and only after that does a high `burst_i` start a new ramp-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_i | input | 1 | Burst active level |
| strobe_i | input | 1 | One-cycle sample strobe |
| i_in | input | SW (12) | Signed in-phase sample |
| q_in | input | SW (12) | Signed quadrature sample |
| i_out | output | SW (12) | Scaled in-phase sample, registered |
| q_out | output | SW (12) | Scaled quadrature sample, registered |
| done_o | output | 1 | High once the ramp-down and silent tail have finished |

## Verification
The assertions check several properties on every cycle. Outputs and the done flag move only on strobes. No scaled output exceeds the magnitude of its input. The done flag never coexists with a nonzero output. The table gain never exceeds unity. The exact curve values need the bench's directed scenarios, and so do the half-up rounding of odd products, the mirrored fall after an early burst end, the tail length, and the way a burst level during the fall is ignored. The bench computes these values from the cosine formula and counts strobes on its own.

// File: rtl/burst_ramp_pkg.sv
package burst_ramp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RISE,
        PH_FULL,
        PH_FALL,
        PH_QUIET,
        PH_DONE
    } phase_e;

    // Gain of rise step k for a rise spanning span steps:
    // unity * sin^2(pi*k/(2*span)) == unity * (0.5 - 0.5*cos(pi*k/span)).
    // Integer Taylor series in Q30 so that it evaluates at elaboration.
    function automatic int ramp_gain(input int k, input int span, input int unity);
        longint pi_q30;
        longint x;
        longint term;
        longint s;
        longint s2;
        pi_q30 = 64'sd3373259426;
        x      = (pi_q30 * longint'(k)) / longint'(2 * span);
        s      = x;
        term   = x;
        for (int i = 1; i <= 7; i++) begin
            term = (((term * x) >>> 30) * x) >>> 30;
            term = -(term / longint'((2 * i) * (2 * i + 1)));
            s    = s + term;
        end
        if (s < 0) s = 0;
        if (s > (64'sd1 <<< 30)) s = 64'sd1 <<< 30;
        s2 = (s * s) >>> 30;
        return int'((s2 * longint'(unity) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/burst_ramp_lut.sv
module burst_ramp_lut #(
    parameter int SPAN = 64,
    parameter int GW   = 10,
    parameter int IW   = $clog2(SPAN + 1)
) (
    input  logic [IW-1:0] idx,
    output logic [GW-1:0] gain
);
    import burst_ramp_pkg::*;

    localparam int NENT  = SPAN + 1;
    localparam int UNITY = 1 << (GW - 1);

    logic [GW-1:0] tbl [NENT];

    for (genvar k = 0; k < NENT; k++) begin : g_ent
        localparam int VAL = ramp_gain(k, SPAN, UNITY);
        assign tbl[k] = GW'(VAL);
    end

    always_comb begin
        if (int'(idx) < NENT) gain = tbl[idx];
        else                  gain = '0;
    end
endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq #(
    parameter int SPS        = 32,
    parameter int RAMP_SYMS  = 2,
    parameter int QUIET_SYMS = 2,
    parameter int RAMP_LEN   = RAMP_SYMS * SPS,
    parameter int QUIET_LEN  = QUIET_SYMS * SPS,
    parameter int CW         = $clog2(((RAMP_LEN > QUIET_LEN) ? RAMP_LEN : QUIET_LEN) + 2),
    parameter int IW         = $clog2(RAMP_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          burst,
    output logic [IW-1:0] idx,
    output logic          done
);
    import burst_ramp_pkg::*;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t          st_d, st_q;
    phase_e        eff_ph;
    logic [CW-1:0] eff_cnt;

    always_comb begin
        eff_ph  = st_q.ph;
        eff_cnt = st_q.cnt;
        if ((st_q.ph == PH_IDLE || st_q.ph == PH_DONE) && burst) begin
            eff_ph  = PH_RISE;
            eff_cnt = '0;
        end else if (st_q.ph == PH_RISE && !burst) begin
            eff_ph  = PH_FALL;
            eff_cnt = CW'(RAMP_LEN) - st_q.cnt;
        end else if (st_q.ph == PH_FULL && !burst) begin
            eff_ph  = PH_FALL;
            eff_cnt = '0;
        end

        unique case (eff_ph)
            PH_RISE: idx = IW'(eff_cnt);
            PH_FULL: idx = IW'(RAMP_LEN);
            PH_FALL: idx = IW'(RAMP_LEN) - IW'(eff_cnt);
            default: idx = '0;
        endcase

        st_d = st_q;
        if (strobe) begin
            st_d.ph  = eff_ph;
            st_d.cnt = eff_cnt + 1'b1;
            unique case (eff_ph)
                PH_RISE: if (eff_cnt >= CW'(RAMP_LEN - 1)) begin
                    st_d.ph  = PH_FULL;
                    st_d.cnt = '0;
                end
                PH_FALL: if (eff_cnt >= CW'(RAMP_LEN - 1)) begin
                    st_d.ph  = PH_QUIET;
                    st_d.cnt = '0;
                end
                PH_QUIET: if (eff_cnt >= CW'(QUIET_LEN - 1)) begin
                    st_d.ph  = PH_DONE;
                    st_d.cnt = '0;
                end
                default: st_d.cnt = '0;
            endcase
            st_d.done = (st_d.ph == PH_DONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
endmodule

// File: rtl/burst_ramp_lane.sv
module burst_ramp_lane #(
    parameter int SW = 12,
    parameter int GW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [GW-1:0]        gain,
    input  logic signed [SW-1:0] x,
    output logic signed [SW-1:0] y
);
    localparam int PW   = SW + GW + 1;
    localparam int FRAC = GW - 1;
    localparam int MAXI = (1 << (SW - 1)) - 1;
    localparam logic signed [PW-1:0] MAXV = PW'(MAXI);
    localparam logic signed [PW-1:0] MINV = PW'(-MAXI - 1);
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

    logic signed [PW-1:0] xs, gs, prod, rnd, sat;
    logic signed [SW-1:0] y_d, y_q;

    always_comb begin
        xs   = PW'(x);
        gs   = PW'(signed'({1'b0, gain}));
        prod = xs * gs;
        rnd  = (prod + HALF) >>> FRAC;
        if (rnd > MAXV)      sat = MAXV;
        else if (rnd < MINV) sat = MINV;
        else                 sat = rnd;
        y_d = en ? SW'(sat) : y_q;
    end

    always_ff @(posedge clk) begin
        if (rst) y_q <= '0;
        else     y_q <= y_d;
    end

    assign y = y_q;
endmodule

// File: rtl/burst_ramp.sv
module burst_ramp #(
    parameter int SW         = 12,
    parameter int GW         = 10,
    parameter int SPS        = 32,
    parameter int RAMP_SYMS  = 2,
    parameter int QUIET_SYMS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 burst_i,
    input  logic                 strobe_i,
    input  logic signed [SW-1:0] i_in,
    input  logic signed [SW-1:0] q_in,
    output logic signed [SW-1:0] i_out,
    output logic signed [SW-1:0] q_out,
    output logic                 done_o
);
    localparam int RAMP_LEN = RAMP_SYMS * SPS;
    localparam int IW       = $clog2(RAMP_LEN + 1);
    localparam int LANES    = 2;

    logic [IW-1:0]        idx_w;
    logic [GW-1:0]        gain_w;
    logic signed [SW-1:0] lane_x [LANES];
    logic signed [SW-1:0] lane_y [LANES];

    burst_ramp_seq #(
        .SPS(SPS), .RAMP_SYMS(RAMP_SYMS), .QUIET_SYMS(QUIET_SYMS), .IW(IW)
    ) u_seq (
        .clk(clk), .rst(rst), .strobe(strobe_i), .burst(burst_i),
        .idx(idx_w), .done(done_o)
    );

    burst_ramp_lut #(.SPAN(RAMP_LEN), .GW(GW), .IW(IW)) u_lut (
        .idx(idx_w), .gain(gain_w)
    );

    assign lane_x[0] = i_in;
    assign lane_x[1] = q_in;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        burst_ramp_lane #(.SW(SW), .GW(GW)) u_lane (
            .clk(clk), .rst(rst), .en(strobe_i), .gain(gain_w),
            .x(lane_x[l]), .y(lane_y[l])
        );
    end

    assign i_out = lane_y[0];
    assign q_out = lane_y[1];
endmodule

// File: rtl/burst_ramp_chk.sv
module burst_ramp_chk #(
    parameter int SW = 12,
    parameter int GW = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 strobe,
    input logic signed [SW-1:0] i_in,
    input logic signed [SW-1:0] q_in,
    input logic signed [SW-1:0] i_out,
    input logic signed [SW-1:0] q_out,
    input logic                 done,
    input logic [GW-1:0]        gain
);
    localparam logic [GW-1:0] UNITY = GW'(1 << (GW - 1));

    logic signed [SW:0] ei_in, eq_in, ei_out, eq_out;
    logic [SW:0] mi_in, mq_in, mi_out, mq_out;

    always_comb begin
        ei_in  = (SW+1)'(i_in);
        eq_in  = (SW+1)'(q_in);
        ei_out = (SW+1)'(i_out);
        eq_out = (SW+1)'(q_out);
        mi_in  = (ei_in  < 0) ? unsigned'(-ei_in)  : unsigned'(ei_in);
        mq_in  = (eq_in  < 0) ? unsigned'(-eq_in)  : unsigned'(eq_in);
        mi_out = (ei_out < 0) ? unsigned'(-ei_out) : unsigned'(ei_out);
        mq_out = (eq_out < 0) ? unsigned'(-eq_out) : unsigned'(eq_out);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (i_out == '0 && q_out == '0 && !done));

    a_r9_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(i_out) && $stable(q_out) && $stable(done)));

    a_r8_no_growth: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (mi_out <= $past(mi_in) && mq_out <= $past(mq_in)));

    a_r7_done_silent: assert property (@(posedge clk) disable iff (rst)
        done |-> (i_out == '0 && q_out == '0));

    a_r7_done_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(strobe));

    a_r3_gain_within_unity: assert property (@(posedge clk) disable iff (rst)
        gain <= UNITY);
endmodule

bind burst_ramp burst_ramp_chk #(.SW(SW), .GW(GW)) u_chk (
    .clk(clk), .rst(rst), .strobe(strobe_i),
    .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out),
    .done(done_o), .gain(gain_w)
);

// File: tb/burst_ramp_test.sv
module burst_ramp_test;
    localparam int SW   = 12;
    localparam int SPS  = 32;
    localparam int SPAN = 2 * SPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_i = 1'b0;
    logic strobe_i = 1'b0;
    logic signed [SW-1:0] i_in = '0;
    logic signed [SW-1:0] q_in = '0;
    logic signed [SW-1:0] i_out, q_out;
    logic done_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_ramp uut (
        .clk(clk), .rst(rst), .burst_i(burst_i), .strobe_i(strobe_i),
        .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out), .done_o(done_o)
    );

    function automatic int up_gain(input int k);
        real th;
        th = 3.14159265358979 * real'(k) / real'(SPAN);
        return int'($floor(512.0 * (0.5 - 0.5 * $cos(th)) + 0.5));
    endfunction

    function automatic int scale(input int x, input int g);
        return int'($floor((real'(x) * real'(g) + 256.0) / 512.0));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // gain may differ by one step from the real-valued curve
    task automatic chk_scaled(input string req, input int x, input int act, input int g);
        int e;
        checks++;
        e = scale(x, g);
        if (act != e && act != scale(x, (g > 0) ? g - 1 : g) && act != scale(x, (g < 512) ? g + 1 : g)) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, e);
        end
    endtask

    task automatic push(input int xi, input int xq);
        @(negedge clk);
        strobe_i = 1'b1;
        i_in = SW'(xi);
        q_in = SW'(xq);
        @(negedge clk);
        strobe_i = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 i_out", int'(i_out), 0);
        chk("R1 q_out", int'(q_out), 0);
        chk("R1 done", int'(done_o), 0);
        rst = 1'b0;
    endtask

    task automatic t_idle;
        burst_i = 1'b0;
        push(1500, -700);
        chk("R2 idle i", int'(i_out), 0);
        push(-2048, 2047);
        chk("R2 idle q", int'(q_out), 0);
    endtask

    task automatic t_rise;
        burst_i = 1'b1;
        for (int k = 0; k < SPAN; k++) begin
            int xi, xq;
            xi = (k == SPS) ? 3 : 2000 - 10 * k;
            xq = (k == SPS) ? -3 : -1800 + 7 * k;
            push(xi, xq);
            if (k == 0) begin
                chk("R3 first rise sample i", int'(i_out), 0);
            end else if (k == SPS) begin
                chk("R8 half-up positive", int'(i_out), 2);
                chk("R8 half-up negative", int'(q_out), -1);
            end else begin
                chk_scaled("R3 rise i", xi, int'(i_out), up_gain(k));
                chk_scaled("R3 rise q", xq, int'(q_out), up_gain(k));
            end
        end
    endtask

    task automatic t_full;
        int vals [5] = '{-2048, 2047, -1, 0, 333};
        foreach (vals[n]) begin
            push(vals[n], -vals[n] / 2);
            chk("R4 full i", int'(i_out), vals[n]);
            chk("R4 full q", int'(q_out), -vals[n] / 2);
        end
        repeat (3) @(negedge clk);
        chk("R9 hold without strobe", int'(i_out), 333);
    endtask

    task automatic t_fall;
        burst_i = 1'b0;
        for (int k = 0; k < SPAN; k++) begin
            push(1900 - 5 * k, -1234);
            chk_scaled("R5 fall i", 1900 - 5 * k, int'(i_out), up_gain(SPAN - k));
            chk_scaled("R5 fall q", -1234, int'(q_out), up_gain(SPAN - k));
        end
        chk("R6 done low after fall", int'(done_o), 0);
    endtask

    task automatic t_quiet;
        for (int k = 0; k < SPAN; k++) begin
            push(1111, -999);
            chk("R6 tail silent", int'(i_out), 0);
            if (k < SPAN - 1) chk("R6 done low in tail", int'(done_o), 0);
            else              chk("R7 done after tail", int'(done_o), 1);
        end
    endtask

    task automatic t_done_hold;
        push(800, 800);
        chk("R2 silent after tail", int'(q_out), 0);
        chk("R7 done holds", int'(done_o), 1);
    endtask

    task automatic t_early;
        burst_i = 1'b1;
        for (int k = 0; k < 10; k++) begin
            push(1700, 900);
            if (k == 0) chk("R7 done drops on restart", int'(done_o), 0);
            chk_scaled("R3 early rise", 1700, int'(i_out), up_gain(k));
        end
        burst_i = 1'b0;
        for (int j = 0; j < 10; j++) begin
            push(1700, 900);
            chk_scaled("R10 mirrored fall", 1700, int'(i_out), up_gain(10 - j));
        end
        t_quiet();
    endtask

    task automatic t_ignore;
        burst_i = 1'b1;
        for (int k = 0; k < SPAN + 2; k++) push(1000, 1000);
        chk("R4 full before fall", int'(i_out), 1000);
        burst_i = 1'b0;
        for (int k = 0; k < SPAN; k++) begin
            if (k == 3) burst_i = 1'b1;
            push(1600, -1600);
            chk_scaled("R11 fall continues", 1600, int'(i_out), up_gain(SPAN - k));
        end
        for (int k = 0; k < SPAN; k++) begin
            push(1600, -1600);
            chk("R11 tail silent despite burst", int'(i_out), 0);
        end
        chk("R11 done after tail", int'(done_o), 1);
        push(1600, -1600);
        chk("R11 restart done low", int'(done_o), 0);
        chk("R11 restart zero gain", int'(i_out), 0);
        push(1600, -1600);
        chk_scaled("R11 restart rise", 1600, int'(i_out), up_gain(1));
    endtask

    initial begin
        t_reset();
        t_idle();
        t_rise();
        t_full();
        t_fall();
        t_quiet();
        t_done_hold();
        t_early();
        t_ignore();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule